// File: doc/BRIEF.md
# Channel Fault Timer with Latch-Off and Auto-Restart

This block decides, cycle by cycle, whether one power channel's gate command is on. While the channel sits in current limit it spends a programmable time budget, counted in ticks of 0.05 ms. When the budget runs out, the block turns the gate off and reports a fault. A global mode input then selects one of two behaviours. In latch-off mode the channel waits for software to toggle its enable bit. In auto-restart mode it cools down for sixteen budgets and then switches itself back on. A fast-trip pulse does not wait for the timer: it drops the gate at once and starts a cool-down.

The budget is built from a 5-bit code. Each set bit adds a binary weight, with bit 0 worth 0.45 ms (9 ticks) and each higher bit worth twice the one below it. The code register that feeds this input resets to 00001. Three single-cycle event outputs go to the status register bank: fault expired, entry into current limit, and fast trip.

Top module: `flt_guard`

## Requirements
- R1: While `rst` is high at a clock edge, `gate_on`, `fault_exp`, `oc_entry` and `ftrip_evt` are all 0 after that edge.
- R2: From the off state, `chan_en` = 1 at an edge turns `gate_on` on after that edge. `chan_en` = 0 at any edge turns `gate_on` off after that edge and clears both timers. While the channel is disabled, `ftrip_in` and `ilim_act` raise no events.
- R3: The fault budget in ticks is `ftime_code` × 9: bit 0 weighs 9 ticks, bit 1 18, bit 2 36, bit 3 72 and bit 4 144. The fault expires at the tick that brings the count of ticks spent in limit up to the budget. A code of 0 expires at the first tick in limit.
- R4: If `ilim_act` is low at an edge before expiry, the fault count returns to zero, and a full budget is needed again.
- R5: At expiry, `fault_exp` is high for exactly one cycle, and `gate_on` is already low in that same cycle.
- R6: With `auto_retry` = 0, a fault expiry leaves `gate_on` low until `chan_en` has been 0 at an edge and then 1 at a later edge.
- R7: With `auto_retry` = 1, after expiry the gate stays off until the tick that brings the cool-down count to 16 × budget (at least one tick). The gate is on after that edge.
- R8: `ftrip_in` = 1 at an edge while the gate is on and enabled turns the gate off after that edge and pulses `ftrip_evt` for one cycle. It raises no `fault_exp`. The block then runs the R7 cool-down and restarts, in either mode.
- R9: `oc_entry` pulses for one cycle after an edge where the gate is on, `ilim_act` is 1, and `ilim_act` was 0 at the previous edge.
- R10: Both timers advance only at edges where `tick` = 1. Time spent in limit without ticks uses no budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable bit |
| ilim_act | input | 1 | Level: channel is in current limit |
| ftrip_in | input | 1 | Pulse: fast-trip threshold crossed |
| tick | input | 1 | One-cycle strobe every 0.05 ms |
| ftime_code | input | 5 | Binary-weighted fault-time code |
| auto_retry | input | 1 | 1 = restart after cool-down, 0 = latch off |
| gate_on | output | 1 | Channel gate command |
| fault_exp | output | 1 | Pulse: fault budget used up |
| oc_entry | output | 1 | Pulse: current limit entered while on |
| ftrip_evt | output | 1 | Pulse: fast trip acted on |

## Verification
The assertions assume that the inputs are synchronous to `clk`, and that `ftrip_in` and `tick` are single-cycle strobes. They make no assumption about how `ftime_code` or `auto_retry` change. The bench drives every input one time unit after the edge and holds it until the next edge. In the random phase the fault-time code stays at small values and changes only rarely, so that many complete cool-downs fit into the run. Enable toggles rarely enough that both the latch-off path and the restart path are reached.

// File: rtl/flt_pkg.sv
package flt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_COOL  = 2'd2,
        ST_LATCH = 2'd3
    } flt_state_e;

    typedef struct packed {
        logic expired;
        logic oc;
        logic ftrip;
    } flt_evt_t;

    localparam flt_evt_t EVT_NONE = '{expired: 1'b0, oc: 1'b0, ftrip: 1'b0};

endpackage

// File: rtl/flt_span_ctr.sv
module flt_span_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;
    logic [W:0]   nxt;

    always_comb begin
        nxt = {1'b0, cnt} + (W+1)'(1);
        hit = run && tick && (nxt >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst || !run || hit)
            cnt <= '0;
        else if (tick)
            cnt <= nxt[W-1:0];
    end

    // R4
    cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(cnt));

endmodule

// File: rtl/flt_seq.sv
module flt_seq
    import flt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     chan_en,
    input  logic     ilim_act,
    input  logic     ftrip_in,
    input  logic     auto_retry,
    input  logic     flt_hit,
    input  logic     cool_hit,
    output logic     flt_run,
    output logic     cool_run,
    output logic     gate_on,
    output flt_evt_t evt
);
    flt_state_e state;
    logic       ilim_q;

    always_comb begin
        gate_on  = (state == ST_ON);
        flt_run  = (state == ST_ON) && chan_en && ilim_act && !ftrip_in;
        cool_run = (state == ST_COOL) && chan_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_OFF;
            ilim_q <= 1'b0;
            evt    <= EVT_NONE;
        end else begin
            evt    <= EVT_NONE;
            evt.oc <= (state == ST_ON) && ilim_act && !ilim_q;
            ilim_q <= ilim_act;
            if (!chan_en) begin
                state <= ST_OFF;
            end else begin
                case (state)
                    ST_OFF:  state <= ST_ON;
                    ST_ON: begin
                        if (ftrip_in) begin
                            evt.ftrip <= 1'b1;
                            state     <= ST_COOL;
                        end else if (flt_hit) begin
                            evt.expired <= 1'b1;
                            state       <= auto_retry ? ST_COOL : ST_LATCH;
                        end
                    end
                    ST_COOL: if (cool_hit) state <= ST_ON;
                    ST_LATCH: state <= ST_LATCH;
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    // R8
    ftrip_off_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_on && chan_en && ftrip_in) |=> !gate_on);

    // R5
    exp_gate_chk: assert property (@(posedge clk) disable iff (rst)
        evt.expired |-> !gate_on);

    // R2
    dis_off_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !gate_on);

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH) |=> !gate_on);

    // R8
    evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.expired, evt.ftrip}));

    // R9
    oc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        evt.oc |-> $past(gate_on));

endmodule

// File: rtl/flt_guard.sv
module flt_guard
    import flt_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int STEP_TICKS = 9,
    parameter int COOL_MULT  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              ilim_act,
    input  logic              ftrip_in,
    input  logic              tick,
    input  logic [CODE_W-1:0] ftime_code,
    input  logic              auto_retry,
    output logic              gate_on,
    output logic              fault_exp,
    output logic              oc_entry,
    output logic              ftrip_evt
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int FLT_W    = $clog2(CODE_MAX * STEP_TICKS + 1);
    localparam int COOL_W   = $clog2(CODE_MAX * STEP_TICKS * COOL_MULT + 1);

    logic [FLT_W-1:0]  flt_lim;
    logic [COOL_W-1:0] cool_lim;
    logic              flt_run, cool_run, flt_hit, cool_hit;
    flt_evt_t          evt;

    always_comb begin
        flt_lim  = FLT_W'(ftime_code) * FLT_W'(STEP_TICKS);
        cool_lim = COOL_W'(flt_lim) * COOL_W'(COOL_MULT);
    end

    flt_span_ctr #(.W(FLT_W)) u_flt_ctr (
        .clk   (clk),
        .rst   (rst),
        .run   (flt_run),
        .tick  (tick),
        .limit (flt_lim),
        .hit   (flt_hit)
    );

    flt_span_ctr #(.W(COOL_W)) u_cool_ctr (
        .clk   (clk),
        .rst   (rst),
        .run   (cool_run),
        .tick  (tick),
        .limit (cool_lim),
        .hit   (cool_hit)
    );

    flt_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en),
        .ilim_act   (ilim_act),
        .ftrip_in   (ftrip_in),
        .auto_retry (auto_retry),
        .flt_hit    (flt_hit),
        .cool_hit   (cool_hit),
        .flt_run    (flt_run),
        .cool_run   (cool_run),
        .gate_on    (gate_on),
        .evt        (evt)
    );

    assign fault_exp = evt.expired;
    assign oc_entry  = evt.oc;
    assign ftrip_evt = evt.ftrip;

endmodule

// File: tb/flt_guard_test.sv
module flt_guard_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, il = 1'b0, ft = 1'b0, tk = 1'b1, mode = 1'b0;
    logic [4:0] code = 5'd1;
    logic       gate_on, fault_exp, oc_entry, ftrip_evt;

    int    n_run = 0, n_fail = 0;
    string req = "R1";

    int ms = 0, mcnt = 0, mcool = 0;
    bit milq = 0, eg = 0, efe = 0, eoc = 0, eft = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flt_guard uut (
        .clk(clk), .rst(rst), .chan_en(en), .ilim_act(il), .ftrip_in(ft),
        .tick(tk), .ftime_code(code), .auto_retry(mode),
        .gate_on(gate_on), .fault_exp(fault_exp), .oc_entry(oc_entry),
        .ftrip_evt(ftrip_evt)
    );

    function automatic int budget(input logic [4:0] c);
        int b = 0;
        for (int i = 0; i < 5; i++) if (c[i]) b += 9 << i;
        return b;
    endfunction

    task automatic model_step();
        int  lim, cl;
        bit  frun, crun;
        efe = 0; eoc = 0; eft = 0;
        if (rst) begin
            ms = 0; mcnt = 0; mcool = 0; milq = 0;
        end else begin
            lim  = budget(code);
            cl   = lim * 16;
            frun = (ms == 1) && en && il && !ft;
            crun = (ms == 2) && en;
            if (ms == 1 && il && !milq) eoc = 1;
            milq = il;
            if (!en) ms = 0;
            else case (ms)
                0: ms = 1;
                1: if (ft) begin
                       eft = 1; ms = 2;
                   end else if (il && tk) begin
                       if (mcnt + 1 >= lim) begin
                           efe = 1; mcnt = 0; ms = mode ? 2 : 3;
                       end else mcnt++;
                   end
                2: if (tk) begin
                       if (mcool + 1 >= cl) begin ms = 1; mcool = 0; end
                       else mcool++;
                   end
                default: ;
            endcase
            if (!frun) mcnt = 0;
            if (!crun) mcool = 0;
        end
        eg = (ms == 1);
    endtask

    task automatic check1(input string nm, input logic a, input bit e);
        n_run++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, nm, a, e);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            model_step();
            check1("gate_on", gate_on, eg);
            check1("fault_exp", fault_exp, efe);
            check1("oc_entry", oc_entry, eoc);
            check1("ftrip_evt", ftrip_evt, eft);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        req = "R1"; cyc(3); rst = 0;
        // R2: inputs ignored while disabled, then enable
        req = "R2"; il = 1; ft = 1; cyc(3); il = 0; ft = 0; cyc(2);
        en = 1; cyc(2);
        // R9: entering limit while on
        req = "R9"; il = 1; cyc(1);
        // R3, R5: expiry after 9 ticks with code 1
        req = "R3,R5"; cyc(12);
        // R6: latched until enable toggles
        req = "R6"; il = 0; cyc(30); en = 0; cyc(1); en = 1; cyc(3);
        // R4: leaving limit restarts the count
        req = "R4"; il = 1; cyc(8); il = 0; cyc(1); il = 1; cyc(8); il = 0; cyc(1);
        il = 1; cyc(10); il = 0; en = 0; cyc(1); en = 1; cyc(2);
        // R10: no ticks, no budget used
        req = "R10"; tk = 0; il = 1; cyc(20); tk = 1; cyc(10);
        il = 0; en = 0; cyc(1); en = 1; cyc(2);
        // R7: auto restart after 16 budgets (code 2 -> 288 ticks)
        req = "R7"; mode = 1; code = 5'd2; il = 1; cyc(20); il = 0; cyc(300);
        // R8: fast trip, cool-down, restart, in latch mode too
        req = "R8"; ft = 1; cyc(1); ft = 0; cyc(300);
        mode = 0; code = 5'd1; ft = 1; cyc(1); ft = 0; cyc(160);
        // R3: code 0 expires on first tick, restarts on next tick
        req = "R3"; mode = 1; code = 5'd0; il = 1; cyc(6); il = 0; cyc(3);
        // R3: code 3 -> 27 ticks
        code = 5'd3; il = 1; cyc(30); il = 0; cyc(440);
        // R2: disable during cool-down stops the restart
        req = "R2"; code = 5'd1; il = 1; cyc(10); il = 0; cyc(5); en = 0; cyc(200);
        en = 1; cyc(3);
        // random phase
        req = "R3,R4,R6,R7,R8,R9,R10";
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 16 == 0) il = ~il;
            ft = ($urandom % 64 == 0);
            tk = $urandom % 2;
            if ($urandom % 500 == 0) en = ~en;
            if ($urandom % 400 == 0) code = 5'($urandom % 4);
            if ($urandom % 700 == 0) mode = ~mode;
            cyc(1);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule